// File: doc/BRIEF.md
# Sixteen-State Add-Compare-Select Stage

This block carries out one trellis step of the path-metric recursion for a rate-independent, sixteen-state convolutional decoder (constraint length five). For each step it takes sixteen signed accumulated state metrics and eight signed branch metrics, one per butterfly. It returns sixteen updated metrics and sixteen survivor decision bits. The larger accumulated value wins, and all arithmetic saturates to the signed metric range.

Butterfly `i` pairs the even old state `2i` with the odd old state `2i+1`. It writes new states `i` and `i+8`. All eight butterflies are evaluated in one cycle, and the results are registered. A valid/ready pair on each side paces the steps. The surrounding decoder normally routes the output metrics, through an external normaliser, back to the input metrics. Branch-metric generation, normalisation and traceback live outside this block.

Top module: `vit_acs_array`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `out_dec` is all zeros. In `out_sm`, state 0 (bits 15:0) holds `INIT_METRIC` (default 4096) and every other state holds 0.
- R2: New state i (i = 0..7) equals max(sat(A+BM), sat(B-BM)). Here A is old state 2i, B is old state 2i+1 and BM is branch metric i. State k occupies bits `16k+15:16k` of a metric bus, and branch metric i occupies bits `16i+15:16i` of `in_bm`.
- R3: New state i+8 equals max(sat(A-BM), sat(B+BM)), with the same operands as R2.
- R4: Every sum and difference saturates to the range -32768..32767 and never wraps.
- R5: Bit i of `out_dec` is 1 exactly when sat(A+BM) >= sat(B-BM). A tie therefore selects the even predecessor.
- R6: Bit i+8 of `out_dec` is 1 exactly when sat(A-BM) >= sat(B+BM), with the same tie rule.
- R7: A step is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its metrics and decisions appear, with `out_valid` = 1, right after that same edge.
- R8: `in_ready` is 1 when no result is held or when `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_sm`, `out_dec` and `out_valid` hold.
- R9: On an edge with no accepted step, `out_sm` and `out_dec` keep their values. `out_valid` drops to 0 if `out_ready` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Step operands are valid |
| in_ready | output | 1 | Block can accept a step |
| in_sm | input | 256 | Sixteen old state metrics, signed 16-bit each |
| in_bm | input | 128 | Eight branch metrics, signed 16-bit each |
| out_valid | output | 1 | Updated metrics and decisions are valid |
| out_ready | input | 1 | Consumer takes the current result |
| out_sm | output | 256 | Sixteen new state metrics |
| out_dec | output | 16 | Survivor decisions, bit k for new state k |

## Verification
Every result is due one register later: the metrics, decisions and `out_valid` produced by a step accepted at one rising edge are checked at the falling edge that follows it. `in_ready` is combinational and is checked in the same half cycle as `out_ready`. Inputs change only on falling edges, and a behavioural integer model updates on each rising edge. At every falling edge all outputs are compared with that model, so stall and idle cycles are checked with the same timing. Directed steps cover ties, saturation at both rails and the reset image.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;
    localparam int DEF_METRIC_W   = 16;
    localparam int DEF_NUM_STATES = 16;
    localparam int DEF_INIT       = 4096;
endpackage

// File: rtl/acs_satadd.sv
module acs_satadd #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] a_x, b_x, wide;

    always_comb begin
        a_x  = {a[W-1], a};
        b_x  = {b[W-1], b};
        wide = sub ? (a_x - b_x) : (a_x + b_x);
        if (wide[W] != wide[W-1]) begin
            y = wide[W] ? NEG_RAIL : POS_RAIL;
        end else begin
            y = wide[W-1:0];
        end
    end
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chk_en,
    input  logic signed [W-1:0] sm_even,
    input  logic signed [W-1:0] sm_odd,
    input  logic signed [W-1:0] bm,
    output logic signed [W-1:0] nm_lo,
    output logic signed [W-1:0] nm_hi,
    output logic                dec_lo,
    output logic                dec_hi
);
    logic signed [W-1:0] c_even_p, c_odd_m, c_even_m, c_odd_p;

    acs_satadd #(.W(W)) u_even_p (.a(sm_even), .b(bm), .sub(1'b0), .y(c_even_p));
    acs_satadd #(.W(W)) u_odd_m  (.a(sm_odd),  .b(bm), .sub(1'b1), .y(c_odd_m));
    acs_satadd #(.W(W)) u_even_m (.a(sm_even), .b(bm), .sub(1'b1), .y(c_even_m));
    acs_satadd #(.W(W)) u_odd_p  (.a(sm_odd),  .b(bm), .sub(1'b0), .y(c_odd_p));

    always_comb begin
        dec_lo = (c_even_p >= c_odd_m);
        dec_hi = (c_even_m >= c_odd_p);
        nm_lo  = dec_lo ? c_even_p : c_odd_m;
        nm_hi  = dec_hi ? c_even_m : c_odd_p;
    end

    // R2 / R5: the low output is the even candidate when chosen, otherwise the strictly larger odd one
    p_pick_lo_r2: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (nm_lo >= c_even_p) && (nm_lo >= c_odd_m));
    p_tie_even_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !dec_lo) |-> (c_odd_m > c_even_p) && (nm_lo == c_odd_m));
    // R3 / R6
    p_pick_hi_r3: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (nm_hi >= c_even_m) && (nm_hi >= c_odd_p));
    p_tie_even_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !dec_hi) |-> (c_odd_p > c_even_m) && (nm_hi == c_odd_p));
    // R4: same-sign addition never flips sign
    p_no_wrap_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !sm_even[W-1] && !bm[W-1]) |-> !c_even_p[W-1]);
    p_no_wrap_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_en && sm_odd[W-1] && !bm[W-1]) |-> c_odd_m[W-1]);
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
    import vit_acs_pkg::*;
#(
    parameter int MW          = DEF_METRIC_W,
    parameter int NUM_STATES  = DEF_NUM_STATES,
    parameter int INIT_METRIC = DEF_INIT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [NUM_STATES*MW-1:0]   in_sm,
    input  logic [NUM_STATES/2*MW-1:0] in_bm,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NUM_STATES*MW-1:0]   out_sm,
    output logic [NUM_STATES-1:0]      out_dec
);
    localparam int NBF = NUM_STATES / 2;
    localparam int SMW = NUM_STATES * MW;
    localparam logic [MW-1:0]  INIT_W   = MW'(INIT_METRIC);
    localparam logic [SMW-1:0] INIT_VEC = {{(SMW-MW){1'b0}}, INIT_W};

    typedef struct packed {
        logic                  vld;
        logic [SMW-1:0]        sm;
        logic [NUM_STATES-1:0] dec;
    } acs_regs_t;

    acs_regs_t st_d, st_q;
    logic [SMW-1:0]        nm_all;
    logic [NUM_STATES-1:0] dec_all;
    logic                  fire;

    assign in_ready  = !st_q.vld || out_ready;
    assign fire      = in_valid && in_ready;
    assign out_valid = st_q.vld;
    assign out_sm    = st_q.sm;
    assign out_dec   = st_q.dec;

    for (genvar i = 0; i < NBF; i++) begin : g_bf
        acs_butterfly #(.W(MW)) u_bf (
            .clk     (clk),
            .rst     (rst),
            .chk_en  (fire),
            .sm_even (in_sm[(2*i)*MW +: MW]),
            .sm_odd  (in_sm[(2*i+1)*MW +: MW]),
            .bm      (in_bm[i*MW +: MW]),
            .nm_lo   (nm_all[i*MW +: MW]),
            .nm_hi   (nm_all[(i+NBF)*MW +: MW]),
            .dec_lo  (dec_all[i]),
            .dec_hi  (dec_all[i+NBF])
        );
    end

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.vld = 1'b1;
            st_d.sm  = nm_all;
            st_d.dec = dec_all;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld <= 1'b0;
            st_q.sm  <= INIT_VEC;
            st_q.dec <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an accepted step shows up after exactly one edge
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
    // R8: a held result is frozen
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_sm) && $stable(out_dec));
    // R9: idle edges keep the metrics
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sm) && $stable(out_dec));
endmodule

// File: tb/vit_acs_array_tb.sv
module vit_acs_array_tb;
    localparam int NS = 16;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic [NS*16-1:0] in_sm = '0;
    logic [NB*16-1:0] in_bm = '0;
    logic in_ready, out_valid;
    logic [NS*16-1:0] out_sm;
    logic [NS-1:0] out_dec;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    int  m_sm [NS];
    bit  m_dec [NS];
    bit  m_vld;
    bit  model_on = 0;

    always #2 clk = ~clk;

    vit_acs_array u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sm(in_sm), .in_bm(in_bm), .out_valid(out_valid), .out_ready(out_ready),
        .out_sm(out_sm), .out_dec(out_dec)
    );

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int get_sm(logic [NS*16-1:0] bus, int k);
        return int'($signed(bus[k*16 +: 16]));
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_vld = 0;
            for (int k = 0; k < NS; k++) begin
                m_sm[k]  = (k == 0) ? 4096 : 0;
                m_dec[k] = 0;
            end
        end else if (in_valid && (!m_vld || out_ready)) begin
            for (int i = 0; i < NB; i++) begin
                int a, b, bm, ep, om, em, op;
                a  = get_sm(in_sm, 2*i);
                b  = get_sm(in_sm, 2*i+1);
                bm = int'($signed(in_bm[i*16 +: 16]));
                ep = sat16(a + bm); om = sat16(b - bm);
                em = sat16(a - bm); op = sat16(b + bm);
                m_dec[i]    = (ep >= om);
                m_dec[i+NB] = (em >= op);
                m_sm[i]     = m_dec[i] ? ep : om;
                m_sm[i+NB]  = m_dec[i+NB] ? em : op;
            end
            m_vld = 1;
        end else if (out_ready) begin
            m_vld = 0;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R7 out_valid", int'(out_valid), int'(m_vld));
            check("R8 in_ready", int'(in_ready), int'(!m_vld || out_ready));
            for (int k = 0; k < NS; k++) begin
                check(k < NB ? "R2 metric" : "R3 metric", get_sm(out_sm, k), m_sm[k]);
                check(k < NB ? "R5 decision" : "R6 decision", int'(out_dec[k]), int'(m_dec[k]));
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    task automatic one_step(input logic [NS*16-1:0] sm, input logic [NB*16-1:0] bm);
        @(negedge clk);
        in_sm = sm; in_bm = bm; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [NS*16-1:0] sm;
        logic [NB*16-1:0] bm;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset image
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 state0", get_sm(out_sm, 0), 4096);
        check("R1 state5", get_sm(out_sm, 5), 0);
        check("R1 dec", int'(out_dec), 0);
        model_on = 1;

        // Ties: all zero metrics and branch metrics
        one_step('0, '0);
        check("R5 tie low group", int'(out_dec[7:0]), 255);
        check("R6 tie high group", int'(out_dec[15:8]), 255);

        // Saturation at both rails, butterfly 0 high, butterfly 1 low
        sm = '0; bm = '0;
        sm[0*16 +: 16] = 16'sd32000;  sm[1*16 +: 16] = -16'sd32000; bm[0 +: 16] = 16'sd1000;
        sm[2*16 +: 16] = -16'sd32700; sm[3*16 +: 16] = -16'sd32700; bm[16 +: 16] = -16'sd500;
        one_step(sm, bm);
        check("R4 positive rail", get_sm(out_sm, 0), 32767);
        check("R4 state8", get_sm(out_sm, 8), 31000);
        check("R4 negative side state1", get_sm(out_sm, 1), -32200);
        check("R5 odd wins", int'(out_dec[1]), 0);
        check("R6 state9", get_sm(out_sm, 9), -32200);

        // R9 idle: nothing accepted, metrics kept, valid dropped
        @(negedge clk);
        check("R9 valid drop", int'(out_valid), 0);
        check("R9 metric kept", get_sm(out_sm, 0), 32767);

        // R8 stall: result held while consumer is not ready
        @(negedge clk);
        in_sm = '0; in_bm = '0; in_bm[0 +: 16] = 16'sd7; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_bm[0 +: 16] = 16'sd99;
        @(negedge clk);
        check("R8 held metric", get_sm(out_sm, 0), 7);
        check("R8 held ready", int'(in_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        check("R7 new step after release", get_sm(out_sm, 0), 99);
        in_valid = 1'b0;

        // Random traffic, loopback or fresh metrics, random back-pressure
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            in_valid  = $urandom_range(0, 3) != 0;
            out_ready = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 1) == 1) in_sm = out_sm;
            else for (int k = 0; k < NS; k++) in_sm[k*16 +: 16] = 16'($urandom);
            for (int i = 0; i < NB; i++) begin
                if ($urandom_range(0, 7) == 0) in_bm[i*16 +: 16] = 16'($urandom);
                else in_bm[i*16 +: 16] = 16'($signed($urandom_range(0, 400)) - 200);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule